// File: doc/BRIEF.md
# Image Sensor Row-Overhead Sequencer

At each change of row, an image sensor needs a short run of control strobes before its column outputs can be sampled. This block generates them. A line-start request arrives, and the block raises a column precharge strobe and a row-deselect strobe together. It drives a column sample-and-hold control and, when that is allowed, a voltage-averaging strobe. It then gives a single-cycle readout-ready pulse that tells the downstream pixel readout logic that sampling may begin.

The block has two overhead modes:

- **Full-settling mode** keeps sample-and-hold asserted all the time. After the strobes end, it waits a programmed number of settle cycles.
- **Shortened mode** makes sample-and-hold a pulse. The pulse starts together with the strobes, and its end marks the end of the overhead period.

All durations are cycle counts of the block clock. The mode, the durations and the averaging enable are captured only when a sequence is accepted. Settings that are illegal are clamped or ignored, and they set a sticky error flag.

Top module: `row_overhead_seq`

## Requirements
- R1: A line_start seen while idle is accepted. On the next cycle, precharge and rowdesel both go high. They stay high for strobe_len cycles, and a value of 0 counts as 1.
- R2: In full-settling mode, readout_ready is high for exactly one cycle, in cycle S+T+1 after acceptance. S is the strobe length and T is settle_len, where T may be 0. busy is low on the following cycle.
- R3: While the most recently accepted sequence is in full-settling mode, sh_ctrl is high on every cycle. This includes the idle time. After reset the block counts as full-settling, and sh_ctrl goes high on the first cycle after reset is released.
- R4: In shortened mode (mode_short=1), sh_ctrl rises together with the strobes and stays high for H cycles. With averaging off, readout_ready fires in cycle max(S,H)+1.
- R5: In shortened mode with avg_en=1, avg_strobe is high for avg_len cycles (0 counts as 1), starting in cycle max(S,H)+1. One guard cycle follows it, and readout_ready fires in the cycle after the guard.
- R6: avg_en has no effect in full-settling mode: avg_strobe stays low and the timing is unchanged. Accepting such a setting sets cfg_err.
- R7: In shortened mode, H is hold_len clamped to the range [HOLD_MIN, HOLD_MAX], which defaults to 10..20. If a hold_len outside that range is accepted, cfg_err is set.
- R8: cfg_err stays set through any number of later sequences until reset.
- R9: busy is high from the cycle after acceptance through the readout_ready cycle. A line_start seen while busy is ignored.
- R10: A change to mode_short, any length input or avg_en after acceptance has no effect on the sequence in progress.
- R11: A synchronous reset drives all strobes, avg_strobe, readout_ready, busy and cfg_err low and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| line_start | input | 1 | Request to begin the row-overhead sequence |
| mode_short | input | 1 | 1 selects shortened mode, 0 selects full-settling mode |
| strobe_len | input | CNT_W | Precharge and row-deselect width in cycles |
| settle_len | input | CNT_W | Full-settling wait in cycles |
| hold_len | input | CNT_W | Shortened-mode sample-and-hold width in cycles |
| avg_en | input | 1 | Request the averaging strobe (shortened mode only) |
| avg_len | input | CNT_W | Averaging strobe width in cycles |
| precharge | output | 1 | Column precharge strobe |
| rowdesel | output | 1 | Row-deselect strobe |
| sh_ctrl | output | 1 | Column sample-and-hold control |
| avg_strobe | output | 1 | Voltage-averaging strobe |
| readout_ready | output | 1 | One-cycle pulse: pixel sampling may begin |
| busy | output | 1 | A sequence is in progress |
| cfg_err | output | 1 | Sticky configuration-error flag |

## Verification
The bench covers these corner cases:

- A strobe programmed longer than the hold pulse. A design that ends the shortened period on the hold pulse alone would fire ready while precharge is still high.
- A settle length of zero. A design with an off-by-one here would add or drop a cycle before ready.
- Requests that arrive during the ready cycle, and a request held high across several sequences. A design that lets these through would restart the sequence before it ends.
- Inputs changed in the middle of a sequence. A design that does not capture them would switch mode or duration partway through.
- Hold widths on both sides of the legal range, and averaging requested in full-settling mode. A design that gets these wrong would emit an illegal pulse, start averaging, or let the error flag clear.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_SETTLE,
    ST_AVG,
    ST_GUARD,
    ST_READY
  } seq_state_t;

endpackage

// File: rtl/rowseq_downcnt.sv
module rowseq_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         active,
  output logic         last
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - ONE;
  end

  assign active = (cnt_q != '0);
  assign last   = (cnt_q == ONE);

endmodule

// File: rtl/rowseq_cfg.sv
module rowseq_cfg #(
  parameter int CNT_W    = 8,
  parameter int HOLD_MIN = 10,
  parameter int HOLD_MAX = 20
) (
  input  logic             mode_short,
  input  logic [CNT_W-1:0] strobe_len,
  input  logic [CNT_W-1:0] hold_len,
  input  logic             avg_en,
  input  logic [CNT_W-1:0] avg_len,
  output logic [CNT_W-1:0] strobe_eff,
  output logic [CNT_W-1:0] hold_eff,
  output logic [CNT_W-1:0] avg_eff,
  output logic             avg_use,
  output logic             cfg_bad
);
  localparam logic [CNT_W-1:0] HMIN = CNT_W'(HOLD_MIN);
  localparam logic [CNT_W-1:0] HMAX = CNT_W'(HOLD_MAX);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  function automatic logic [CNT_W-1:0] floor_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  function automatic logic [CNT_W-1:0] clamp_hold(input logic [CNT_W-1:0] v);
    if (v < HMIN)      return HMIN;
    else if (v > HMAX) return HMAX;
    else               return v;
  endfunction

  function automatic logic hold_out_of_range(input logic [CNT_W-1:0] v);
    return (v < HMIN) || (v > HMAX);
  endfunction

  assign strobe_eff = floor_one(strobe_len);
  assign avg_eff    = floor_one(avg_len);
  assign hold_eff   = clamp_hold(hold_len);
  assign avg_use    = avg_en && mode_short;
  assign cfg_bad    = (mode_short && hold_out_of_range(hold_len)) ||
                      (!mode_short && avg_en);

  always_comb begin
    AST_HOLD_IN_RANGE: assert (hold_eff >= HMIN && hold_eff <= HMAX); // R7
    AST_STROBE_NONZERO: assert (strobe_eff != '0 && avg_eff != '0); // R1
  end

endmodule

// File: rtl/row_overhead_seq.sv
module row_overhead_seq
  import rowseq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int HOLD_MIN = 10,
  parameter int HOLD_MAX = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic             mode_short,
  input  logic [CNT_W-1:0] strobe_len,
  input  logic [CNT_W-1:0] settle_len,
  input  logic [CNT_W-1:0] hold_len,
  input  logic             avg_en,
  input  logic [CNT_W-1:0] avg_len,
  output logic             precharge,
  output logic             rowdesel,
  output logic             sh_ctrl,
  output logic             avg_strobe,
  output logic             readout_ready,
  output logic             busy,
  output logic             cfg_err
);

  seq_state_t state_q, state_d;

  logic [CNT_W-1:0] strobe_eff, hold_eff, avg_eff;
  logic             avg_use, cfg_bad;

  logic             mode_short_q, avg_use_q;
  logic [CNT_W-1:0] settle_q, avg_q;
  logic             out_en_q, cfg_err_q;

  logic             seq_accept, run_done, main_load;
  logic [CNT_W-1:0] hold_load_val, main_val;
  logic             strb_active, strb_last;
  logic             hold_active, hold_last;
  logic             main_active, main_last;

  rowseq_cfg #(
    .CNT_W(CNT_W), .HOLD_MIN(HOLD_MIN), .HOLD_MAX(HOLD_MAX)
  ) u_cfg (
    .mode_short (mode_short),
    .strobe_len (strobe_len),
    .hold_len   (hold_len),
    .avg_en     (avg_en),
    .avg_len    (avg_len),
    .strobe_eff (strobe_eff),
    .hold_eff   (hold_eff),
    .avg_eff    (avg_eff),
    .avg_use    (avg_use),
    .cfg_bad    (cfg_bad)
  );

  assign seq_accept    = (state_q == ST_IDLE) && line_start;
  assign hold_load_val = mode_short ? hold_eff : '0;

  rowseq_downcnt #(.W(CNT_W)) u_strobe_cnt (
    .clk(clk), .rst(rst), .load(seq_accept), .load_val(strobe_eff),
    .active(strb_active), .last(strb_last)
  );

  rowseq_downcnt #(.W(CNT_W)) u_hold_cnt (
    .clk(clk), .rst(rst), .load(seq_accept), .load_val(hold_load_val),
    .active(hold_active), .last(hold_last)
  );

  assign run_done  = (state_q == ST_RUN) &&
                     (!strb_active || strb_last) &&
                     (!hold_active || hold_last);
  assign main_val  = mode_short_q ? avg_q : settle_q;
  assign main_load = run_done && (mode_short_q ? avg_use_q : (settle_q != '0));

  rowseq_downcnt #(.W(CNT_W)) u_main_cnt (
    .clk(clk), .rst(rst), .load(main_load), .load_val(main_val),
    .active(main_active), .last(main_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (line_start) state_d = ST_RUN;
      ST_RUN: begin
        if (run_done) begin
          if (mode_short_q) state_d = avg_use_q ? ST_AVG : ST_READY;
          else              state_d = (settle_q != '0) ? ST_SETTLE : ST_READY;
        end
      end
      ST_SETTLE: if (main_last) state_d = ST_READY;
      ST_AVG:    if (main_last) state_d = ST_GUARD;
      ST_GUARD:  state_d = ST_READY;
      ST_READY:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      mode_short_q <= 1'b0;
      avg_use_q    <= 1'b0;
      settle_q     <= '0;
      avg_q        <= '0;
      out_en_q     <= 1'b0;
      cfg_err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      out_en_q <= 1'b1;
      if (seq_accept) begin
        mode_short_q <= mode_short;
        avg_use_q    <= avg_use;
        settle_q     <= settle_len;
        avg_q        <= avg_eff;
        if (cfg_bad) cfg_err_q <= 1'b1;
      end
    end
  end

  assign precharge     = strb_active;
  assign rowdesel      = strb_active;
  assign sh_ctrl       = out_en_q && (!mode_short_q || hold_active);
  assign avg_strobe    = (state_q == ST_AVG);
  assign readout_ready = (state_q == ST_READY);
  assign busy          = (state_q != ST_IDLE);
  assign cfg_err       = cfg_err_q;

  AST_STROBE_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    seq_accept |=> (precharge && rowdesel && busy)); // R1
  AST_SHORT_SH_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    (seq_accept && mode_short) |=> (sh_ctrl && precharge)); // R4
  AST_SETTLE_SH_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SETTLE) |-> (sh_ctrl && !precharge && main_active)); // R3
  AST_AVG_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
    avg_strobe |-> (!sh_ctrl && !precharge)); // R5
  AST_NO_AVG_FULL: assert property (@(posedge clk) disable iff (rst)
    !mode_short_q |-> !avg_strobe); // R6
  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    readout_ready |=> (!readout_ready && !busy)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err); // R8
  AST_IGNORE_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && line_start && !readout_ready) |=> busy); // R9

endmodule

// File: tb/row_overhead_seq_tb.sv
`timescale 1ns/1ps
module row_overhead_seq_tb;

  localparam int HMIN = 10;
  localparam int HMAX = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_start = 1'b0;
  logic       mode_short = 1'b0;
  logic [7:0] strobe_len = 8'd2;
  logic [7:0] settle_len = 8'd18;
  logic [7:0] hold_len   = 8'd10;
  logic       avg_en     = 1'b0;
  logic [7:0] avg_len    = 8'd1;
  logic precharge, rowdesel, sh_ctrl, avg_strobe, readout_ready, busy, cfg_err;

  row_overhead_seq u_dut (
    .clk(clk), .rst(rst), .line_start(line_start), .mode_short(mode_short),
    .strobe_len(strobe_len), .settle_len(settle_len), .hold_len(hold_len),
    .avg_en(avg_en), .avg_len(avg_len), .precharge(precharge),
    .rowdesel(rowdesel), .sh_ctrl(sh_ctrl), .avg_strobe(avg_strobe),
    .readout_ready(readout_ready), .busy(busy), .cfg_err(cfg_err)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int cyc = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // behavioural reference: cycle index since acceptance and captured settings
  bit m_act, m_full, m_outen, m_err, m_short, m_avg, cmp_en;
  int m_k, m_end, m_S, m_H, m_T, m_A, m_base;

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0; m_k = 0; m_full = 1; m_outen = 0; m_err = 0; cmp_en = 1;
    end else begin
      m_outen = 1;
      if (m_act) begin
        if (m_k == m_end) m_act = 0;
        else m_k++;
      end else if (line_start) begin
        m_act = 1; m_k = 1;
        m_short = mode_short;
        m_S = (strobe_len == 0) ? 1 : int'(strobe_len);
        m_A = (avg_len == 0) ? 1 : int'(avg_len);
        m_T = int'(settle_len);
        m_avg = avg_en && mode_short;
        m_full = !mode_short;
        if (mode_short) begin
          m_H = int'(hold_len);
          if (m_H < HMIN) begin m_H = HMIN; m_err = 1; end
          if (m_H > HMAX) begin m_H = HMAX; m_err = 1; end
          m_base = (m_S > m_H) ? m_S : m_H;
          m_end = m_base + 1 + (m_avg ? m_A + 1 : 0);
        end else begin
          m_H = 0; m_base = m_S;
          if (avg_en) m_err = 1;
          m_end = m_S + m_T + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R1 precharge", int'(precharge), int'(m_act && m_k <= m_S));
      chk("R1 rowdesel", int'(rowdesel), int'(m_act && m_k <= m_S));
      chk("R3 sh_ctrl", int'(sh_ctrl), int'(m_outen && (m_full || (m_act && m_k <= m_H))));
      chk("R2 readout_ready", int'(readout_ready), int'(m_act && m_k == m_end));
      chk("R5 avg_strobe", int'(avg_strobe),
          int'(m_act && m_avg && m_k > m_base && m_k <= m_base + m_A));
      chk("R9 busy", int'(busy), int'(m_act));
      chk("R7 cfg_err", int'(cfg_err), int'(m_err));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic set_cfg(input bit sm, input int s, input int t, input int h,
                         input bit ae, input int a);
    mode_short = sm; strobe_len = 8'(s); settle_len = 8'(t);
    hold_len = 8'(h); avg_en = ae; avg_len = 8'(a);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_seq(input bit sm, input int s, input int t, input int h,
                         input bit ae, input int a);
    @(negedge clk);
    set_cfg(sm, s, t, h, ae, a);
    line_start = 1;
    @(negedge clk);
    line_start = 0;
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 busy in reset", int'(busy), 0);
    chk("R11 precharge in reset", int'(precharge), 0);
    chk("R11 sh_ctrl in reset", int'(sh_ctrl), 0);
    rst = 0;
    @(negedge clk);
    chk("R3 sh high after reset", int'(sh_ctrl), 1);

    run_seq(0, 2, 18, 10, 0, 1);          // R2 nominal full settle
    run_seq(0, 3, 0, 10, 0, 1);           // R2 zero settle
    run_seq(0, 0, 4, 10, 0, 1);           // R1 zero strobe counts as one
    run_seq(1, 2, 18, 10, 0, 1);          // R4 short, min hold
    run_seq(1, 2, 18, 20, 0, 1);          // R4 short, max hold
    run_seq(1, 25, 18, 12, 0, 1);         // R4 strobe longer than hold
    run_seq(1, 2, 18, 12, 1, 3);          // R5 averaging
    run_seq(1, 2, 18, 15, 1, 0);          // R5 zero averaging counts as one
    chk("R7 no error with legal settings", int'(cfg_err), 0);

    // R9 R10: retrigger and config change mid-sequence
    @(negedge clk);
    set_cfg(0, 2, 18, 10, 0, 1);
    line_start = 1;
    @(negedge clk);
    line_start = 0;
    repeat (4) @(negedge clk);
    set_cfg(1, 9, 2, 13, 1, 5);
    line_start = 1;
    @(negedge clk);
    line_start = 0;
    chk("R10 still busy after mid change", int'(busy), 1);
    chk("R10 sh stays high full mode", int'(sh_ctrl), 1);
    wait_idle();

    // R9 request held high across sequences, including the ready cycle
    @(negedge clk);
    set_cfg(1, 2, 0, 11, 0, 1);
    line_start = 1;
    repeat (40) @(negedge clk);
    line_start = 0;
    wait_idle();

    // R7 hold below range
    run_seq(1, 2, 0, 5, 0, 1);
    chk("R7 cfg_err after short hold", int'(cfg_err), 1);
    run_seq(0, 2, 5, 10, 0, 1);
    chk("R8 cfg_err sticky", int'(cfg_err), 1);

    @(negedge clk); rst = 1; @(negedge clk);
    chk("R11 cfg_err cleared", int'(cfg_err), 0);
    rst = 0;
    run_seq(1, 2, 0, 30, 0, 1);           // R7 hold above range
    chk("R7 cfg_err after long hold", int'(cfg_err), 1);

    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    run_seq(0, 2, 6, 10, 1, 4);           // R6 averaging ignored in full mode
    chk("R6 cfg_err with avg in full mode", int'(cfg_err), 1);

    // R11 reset in the middle of a sequence
    @(negedge clk);
    set_cfg(1, 3, 0, 14, 1, 2);
    line_start = 1;
    @(negedge clk);
    line_start = 0;
    repeat (2) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk("R11 busy after mid reset", int'(busy), 0);
    chk("R11 precharge after mid reset", int'(precharge), 0);
    chk("R11 sh after mid reset", int'(sh_ctrl), 0);
    rst = 0;
    repeat (3) @(negedge clk);
    run_seq(0, 2, 18, 10, 0, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule